// File: doc/BRIEF.md
# MSI doorbell pulse frame

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into one-cycle pulses on a bank of wired interrupt lines. A device writes a global interrupt number to the doorbell register. The frame subtracts the number of its first served interrupt and checks that the result lies inside its range. If it does, the frame pulses the matching local output line for one clock cycle. If it does not, the write is dropped without any report.

Software finds the frame's range through a read-only type register. This register packs the first served interrupt number and the line count into one word. An identification register returns a fixed product code, and a block of optional identification offsets reads as zero. The frame occupies a 4 KB byte-addressed window. Each access is qualified by a size code. Read data and the error flag arrive one cycle after the request. The error flag rises for accesses of the wrong size and for accesses to offsets that have no meaning in that direction.

Top module: `msi_pulse_frame`

## Requirements
- R1: After reset, and in every cycle that follows an idle cycle (req_valid low), irq_out is all zero, rd_data is zero and acc_err is low.
- R2: A read at offset 0x008 with size code 2 (32-bit) returns ((SPI_BASE + 32) << 16) | NUM_OUT on rd_data in the cycle after the request, and acc_err stays low.
- R3: A 32-bit read at offset 0xFCC returns 0x0510_0000 one cycle later, which is product code 0x51 in bits 31:20 with all other bits zero, and acc_err stays low.
- R4: A 32-bit read at any offset from 0xFD0 through 0xFFC returns zero, and acc_err stays low.
- R5: A write at offset 0x040 with size code 1 (16-bit) or 2 (32-bit) whose data bits 9:0 hold an ID in [SPI_BASE+32, SPI_BASE+32+NUM_OUT) drives irq_out bit (ID - SPI_BASE - 32) high for exactly the cycle after the request, with acc_err low.
- R6: A doorbell write whose ID in bits 9:0 falls outside that range pulses no line and raises no error. Data bits 31:10 never affect which line is pulsed.
- R7: A read with any size code other than 2 returns zero and raises acc_err for one cycle. Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit.
- R8: A doorbell write with size code 0 or 3 pulses no line and raises acc_err for one cycle.
- R9: A read at an offset other than 0x008, 0xFCC or 0xFD0 to 0xFFC returns zero and raises acc_err. A write at any offset other than 0x040 pulses no line and raises acc_err.
- R10: Doorbells on consecutive cycles each produce their own pulse. Two writes in a row to the same line keep it high for two cycles. Writes to two different lines light each line for one cycle, in order.
- R11: At most one bit of irq_out is high in any cycle.
- R12: Elaboration fails unless 1 <= NUM_OUT <= 128 and SPI_BASE + 32 + NUM_OUT <= 1020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_size | input | 2 | Access size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| acc_err | output | 1 | One-cycle flag for a rejected access |
| irq_out | output | NUM_OUT | Interrupt lines, one-cycle pulses |

## Verification
While the pulse bank is holding a line high for one doorbell, the decoder is already judging the next request. That next request can be another doorbell, a rejected write or a read. The bench drives doorbells back to back to the same line and to neighbouring lines. It also follows a doorbell at once with wrong-size writes and register reads. Each expected cycle is compared as a whole vector, so a pulse that stretches, shifts or leaks into the next request's error flag or read data is caught.

// File: rtl/msi_pulse_pkg.sv
package msi_pulse_pkg;

  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned DOOR_ID_W  = 10;
  localparam int unsigned MAX_OUT    = 128;
  localparam int unsigned ID_LIMIT   = 1020;
  localparam int unsigned ID_OFFSET  = 32;

  localparam logic [ADDR_W-1:0] OFS_TYPE   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOOR   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT  = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_OPT_LO = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_OPT_HI = 12'hFFC;

  localparam logic [11:0] PRODUCT_CODE = 12'h051;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_TYPE  = 2'd1,
    RSEL_IDENT = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    rd_ok;
    logic    wr_door;
    logic    err;
    rd_sel_e rsel;
  } dec_t;

endpackage

// File: rtl/msi_bus_decode.sv
module msi_bus_decode
  import msi_pulse_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output dec_t              dec
);

  logic is_rd, is_wr;
  logic size_word, size_half_word;
  logic hit_type, hit_ident, hit_opt, hit_door;

  always_comb begin
    is_rd          = req_valid & ~req_write;
    is_wr          = req_valid &  req_write;
    size_word      = (req_size == SZ_WORD);
    size_half_word = (req_size == SZ_HALF) | (req_size == SZ_WORD);
    hit_type       = (req_addr == OFS_TYPE);
    hit_ident      = (req_addr == OFS_IDENT);
    hit_opt        = (req_addr >= OFS_OPT_LO) & (req_addr <= OFS_OPT_HI);
    hit_door       = (req_addr == OFS_DOOR);

    dec.rd_ok   = is_rd & size_word & (hit_type | hit_ident | hit_opt);
    dec.wr_door = is_wr & size_half_word & hit_door;
    dec.err     = (is_rd & ~dec.rd_ok) | (is_wr & ~dec.wr_door);

    if (hit_type)       dec.rsel = RSEL_TYPE;
    else if (hit_ident) dec.rsel = RSEL_IDENT;
    else                dec.rsel = RSEL_ZERO;
  end

endmodule

// File: rtl/msi_range_map.sv
module msi_range_map
  import msi_pulse_pkg::*;
#(
  parameter int unsigned FIRST_ID = 32,
  parameter int unsigned NUM_OUT  = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic [DOOR_ID_W-1:0] door_id,
  output logic                 in_range,
  output logic [IDX_W-1:0]     line_idx
);

  localparam int unsigned CMP_W = DOOR_ID_W + 1;
  localparam logic [CMP_W-1:0] FIRST_C = CMP_W'(FIRST_ID);
  localparam logic [CMP_W-1:0] COUNT_C = CMP_W'(NUM_OUT);

  logic [CMP_W-1:0] id_ext;
  logic [CMP_W-1:0] offset;

  always_comb begin
    id_ext   = {1'b0, door_id};
    offset   = id_ext - FIRST_C;
    in_range = (id_ext >= FIRST_C) & (offset < COUNT_C);
    line_idx = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
  parameter int unsigned NUM_OUT = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [IDX_W-1:0]   line_idx,
  output logic [NUM_OUT-1:0] lines
);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    logic sel_nxt;
    logic line_en;
    logic line_q;

    always_comb begin
      sel_nxt = fire & (line_idx == IDX_W'(g));
      line_en = sel_nxt | line_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q <= 1'b0;
      end else if (line_en) begin
        line_q <= sel_nxt;
      end
    end

    assign lines[g] = line_q;
  end

endmodule

// File: rtl/msi_pulse_frame.sv
module msi_pulse_frame
  import msi_pulse_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 64,
  parameter int unsigned SPI_BASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [11:0]        req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic [31:0]        rd_data,
  output logic               acc_err,
  output logic [NUM_OUT-1:0] irq_out
);

  localparam int unsigned FIRST_ID   = SPI_BASE + ID_OFFSET;
  localparam int unsigned IDX_W      = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam logic [31:0] TYPE_WORD  = (32'(FIRST_ID) << 16) | 32'(NUM_OUT);
  localparam logic [31:0] IDENT_WORD = {PRODUCT_CODE, 20'h0_0000};

  // R12: configuration limits checked at elaboration
  if (NUM_OUT == 0 || NUM_OUT > MAX_OUT) begin : g_bad_count
    $error("msi_pulse_frame: NUM_OUT must lie in 1..%0d", MAX_OUT);
  end
  if (FIRST_ID + NUM_OUT > ID_LIMIT) begin : g_bad_range
    $error("msi_pulse_frame: served ID range ends above %0d", ID_LIMIT);
  end

  dec_t             dec;
  logic             id_hit;
  logic [IDX_W-1:0] id_line;
  logic             fire;
  logic [31:0]      rd_word;
  logic [31:0]      rd_nxt;
  logic             rd_en;
  logic [31:0]      rd_q;
  logic             err_nxt;
  logic             err_q;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[31:DOOR_ID_W];

  msi_bus_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .dec       (dec)
  );

  msi_range_map #(
    .FIRST_ID (FIRST_ID),
    .NUM_OUT  (NUM_OUT),
    .IDX_W    (IDX_W)
  ) u_range (
    .door_id  (req_wdata[DOOR_ID_W-1:0]),
    .in_range (id_hit),
    .line_idx (id_line)
  );

  assign fire = dec.wr_door & id_hit;

  msi_pulse_bank #(
    .NUM_OUT (NUM_OUT),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .line_idx (id_line),
    .lines    (irq_out)
  );

  always_comb begin
    unique case (dec.rsel)
      RSEL_TYPE:  rd_word = TYPE_WORD;
      RSEL_IDENT: rd_word = IDENT_WORD;
      default:    rd_word = '0;
    endcase
    rd_nxt  = dec.rd_ok ? rd_word : '0;
    rd_en   = req_valid | (|rd_q);
    err_nxt = dec.err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_nxt;
      err_q <= err_nxt;
    end
  end

  assign rd_data = rd_q;
  assign acc_err = err_q;

endmodule

// File: rtl/msi_pulse_frame_chk.sv
module msi_pulse_frame_chk #(
  parameter int unsigned NUM_OUT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [11:0]        req_addr,
  input logic [1:0]         req_size,
  input logic [31:0]        rd_data,
  input logic               acc_err,
  input logic [NUM_OUT-1:0] irq_out
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (irq_out == '0 && !acc_err && rd_data == '0));

  p_type_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd2 && req_addr == 12'h008)
      |=> (rd_data[15:0] == 16'(NUM_OUT) && !acc_err));

  p_pulse_from_door_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> $past(req_valid && req_write && req_addr == 12'h040));

  p_bad_read_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 2'd2) |=> (acc_err && rd_data == '0));

  p_bad_write_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_size == 2'd0 || req_size == 2'd3))
      |=> (acc_err && irq_out == '0));

  p_one_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));

endmodule

bind msi_pulse_frame msi_pulse_frame_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rd_data   (rd_data),
  .acc_err   (acc_err),
  .irq_out   (irq_out)
);

// File: tb/msi_pulse_frame_tb_top.sv
`timescale 1ns/1ps
module msi_pulse_frame_tb_top;

  localparam int NUM_OUT = 64;
  localparam int BASE    = 0;
  localparam int FIRST   = BASE + 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_write;
  logic [11:0]        req_addr;
  logic [1:0]         req_size;
  logic [31:0]        req_wdata;
  logic [31:0]        rd_data;
  logic               acc_err;
  logic [NUM_OUT-1:0] irq_out;

  always #2.5 clk = ~clk;

  msi_pulse_frame #(.NUM_OUT(NUM_OUT), .SPI_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_data), .acc_err(acc_err), .irq_out(irq_out)
  );

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  logic [31:0]        q_rd[$];
  logic               q_err[$];
  logic [NUM_OUT-1:0] q_irq[$];
  string              q_tag[$];

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: computes the expected outcome from the requirements and drives.
  task automatic drive(input logic v, input logic w, input logic [11:0] a,
                       input logic [1:0] sz, input logic [31:0] d, input string tag);
    logic [31:0]        e_rd  = '0;
    logic               e_err = 1'b0;
    logic [NUM_OUT-1:0] e_irq = '0;
    int                 id;
    if (v && !w) begin
      if (sz != 2'd2) e_err = 1'b1;
      else if (a == 12'h008) e_rd = (32'(FIRST) << 16) | 32'(NUM_OUT);
      else if (a == 12'hFCC) e_rd = 32'h0510_0000;
      else if (a >= 12'hFD0 && a <= 12'hFFC) e_rd = '0;
      else e_err = 1'b1;
    end else if (v && w) begin
      if (!(sz == 2'd1 || sz == 2'd2) || a != 12'h040) e_err = 1'b1;
      else begin
        id = int'(d[9:0]);
        if (id >= FIRST && id < FIRST + NUM_OUT) e_irq[id - FIRST] = 1'b1;
      end
    end
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    q_rd.push_back(e_rd); q_err.push_back(e_err);
    q_irq.push_back(e_irq); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 12'h000, 2'd0, 32'h0, "R1");
  endtask

  // Monitor: compares one registered result per driven cycle.
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      logic [31:0]        e_rd;
      logic               e_err;
      logic [NUM_OUT-1:0] e_irq;
      string              tag;
      e_rd = q_rd.pop_front(); e_err = q_err.pop_front();
      e_irq = q_irq.pop_front(); tag = q_tag.pop_front();
      checks++;
      if (rd_data !== e_rd || acc_err !== e_err || irq_out !== e_irq) begin
        errors++;
        $display("FAIL %s: actual rd=%h err=%b irq=%h expected rd=%h err=%b irq=%h",
                 tag, rd_data, acc_err, irq_out, e_rd, e_err, e_irq);
      end
      if (tag == "R2") begin
        // R12: the reported range honours the configuration limits
        checks++;
        if (int'(rd_data[15:0]) > 128 || int'(rd_data[31:16]) + int'(rd_data[15:0]) > 1020) begin
          errors++;
          $display("FAIL R12: actual first=%0d count=%0d expected count<=128 end<=1020",
                   rd_data[31:16], rd_data[15:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    #12;
    checks++;
    if (irq_out !== '0 || rd_data !== '0 || acc_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual rd=%h err=%b irq=%h expected all zero",
               rd_data, acc_err, irq_out);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    drive(1, 0, 12'h008, 2'd2, 32'h0, "R2");
    drive(1, 0, 12'hFCC, 2'd2, 32'h0, "R3");
    drive(1, 0, 12'hFD0, 2'd2, 32'h0, "R4");
    drive(1, 0, 12'hFE4, 2'd2, 32'h0, "R4");
    drive(1, 0, 12'hFFC, 2'd2, 32'h0, "R4");
    idle(1);

    drive(1, 1, 12'h040, 2'd2, 32'd32, "R5");
    idle(1);
    drive(1, 1, 12'h040, 2'd2, 32'd95, "R5");
    drive(1, 1, 12'h040, 2'd1, 32'd60, "R5");
    idle(1);

    drive(1, 1, 12'h040, 2'd2, 32'd31, "R6");
    drive(1, 1, 12'h040, 2'd2, 32'd96, "R6");
    drive(1, 1, 12'h040, 2'd2, 32'h0000_03FF, "R6");
    drive(1, 1, 12'h040, 2'd2, 32'hFFFF_FC21, "R6");
    idle(1);

    drive(1, 0, 12'h008, 2'd1, 32'h0, "R7");
    drive(1, 0, 12'hFCC, 2'd3, 32'h0, "R7");
    drive(1, 0, 12'h008, 2'd0, 32'h0, "R7");

    drive(1, 1, 12'h040, 2'd0, 32'd40, "R8");
    drive(1, 1, 12'h040, 2'd3, 32'd40, "R8");
    idle(1);

    drive(1, 0, 12'h040, 2'd2, 32'h0, "R9");
    drive(1, 0, 12'h00C, 2'd2, 32'h0, "R9");
    drive(1, 0, 12'hFFD, 2'd2, 32'h0, "R9");
    drive(1, 1, 12'h008, 2'd2, 32'd40, "R9");
    drive(1, 1, 12'hFCC, 2'd2, 32'd40, "R9");
    drive(1, 1, 12'h044, 2'd2, 32'd40, "R9");
    idle(1);

    // back to back on one line, then on a neighbour (R10, R11)
    drive(1, 1, 12'h040, 2'd2, 32'd40, "R10");
    drive(1, 1, 12'h040, 2'd1, 32'd40, "R10");
    drive(1, 1, 12'h040, 2'd2, 32'd41, "R11");
    drive(1, 1, 12'h040, 2'd2, 32'd42, "R10");
    idle(1);

    // doorbell overlapped by rejected requests and reads
    drive(1, 1, 12'h040, 2'd2, 32'd50, "R5");
    drive(1, 1, 12'h040, 2'd0, 32'd50, "R8");
    drive(1, 1, 12'h040, 2'd2, 32'd51, "R10");
    drive(1, 0, 12'h008, 2'd2, 32'h0, "R2");
    drive(1, 1, 12'h040, 2'd2, 32'd52, "R5");
    drive(1, 0, 12'hFCC, 2'd2, 32'h0, "R3");
    idle(3);

    #20;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule